// File: doc/BRIEF.md
# Move-Addressed Program Counter Unit

This unit owns the program counter of a processor whose only instruction is a data move. Control flow has no opcodes of its own. A move writes a value into one of four destination addresses of this unit, and the address chosen selects the operation: absolute jump, relative branch when the flag is set, subroutine call, or return when the flag is set. When no move targets the unit, the program counter advances by one. The register value drives `fetch_addr` every cycle.

A small last-in, first-out stack inside the unit holds return addresses for calls. If a call finds the stack full, or a taken return finds it empty, the unit sets a sticky error output. Only reset clears these outputs. The unit has no interrupt path. Software that waits for an event polls a flag and uses the conditional forms.

The move on the inputs in a given cycle belongs to the instruction at the current `fetch_addr`. Its effect shows on `fetch_addr` after the next rising clock edge.

Top module: `move_pc_unit`

## Requirements
- R1: While `rst_n` is low, `fetch_addr` is 0 and both error outputs are 0. After `rst_n` rises, `fetch_addr` stays 0 across the next two rising edges and starts counting on the third.
- R2: A cycle with `mv_valid` low gives `fetch_addr` + 1 (modulo 2^ADDR_W) after the edge. `mv_dest`, `mv_data` and `cond_flag` have no effect in such a cycle.
- R3: A move to destination 0 (jump) loads `mv_data` into the program counter, whatever `cond_flag` is.
- R4: A move to destination 1 (branch) with `cond_flag` = 1 adds `mv_data`, read as a two's-complement offset, to the current program counter (modulo 2^ADDR_W). With `cond_flag` = 0 the counter advances by one.
- R5: A move to destination 2 (call) pushes the current program counter + 1 and loads `mv_data`, whatever `cond_flag` is.
- R6: A move to destination 3 (return) with `cond_flag` = 1 and a non-empty stack pops the top entry into the program counter. With `cond_flag` = 0 the counter advances by one and the stack is left unchanged.
- R7: The return stack holds STACK_DEPTH (default 8) entries and returns them in last-in, first-out order.
- R8: A call while the stack holds STACK_DEPTH entries still jumps. Its return address is discarded, the stored entries stay as they are, and `stk_overflow` is set.
- R9: A return with `cond_flag` = 1 on an empty stack advances the counter by one and sets `stk_underflow`.
- R10: Once set, `stk_overflow` and `stk_underflow` stay at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| mv_valid | input | 1 | A move targets this unit in this cycle |
| mv_dest | input | 2 | Destination address: 0 jump, 1 branch, 2 call, 3 return |
| mv_data | input | ADDR_W | Moved value: a target address or a signed offset |
| cond_flag | input | 1 | Condition sampled in the same cycle as the move |
| fetch_addr | output | ADDR_W | Program counter, the next fetch address |
| stk_overflow | output | 1 | Sticky: a call found the return stack full |
| stk_underflow | output | 1 | Sticky: a taken return found the return stack empty |

## Verification
The assertions assume at most one control move per cycle, which holds by construction because all four operations share one destination field. They also assume that `cond_flag`, `mv_dest` and `mv_data` are settled at the rising edge whenever `mv_valid` is high. The bench drives every input on the falling edge, so each one is stable for half a period before the edge that samples it. It sends only legal two-bit destination codes. It reaches the full and empty stack states only through sequences of calls and returns, never by forcing state.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  localparam int unsigned DEST_W = 2;

  localparam logic [DEST_W-1:0] DST_JUMP   = 2'd0;
  localparam logic [DEST_W-1:0] DST_BRANCH = 2'd1;
  localparam logic [DEST_W-1:0] DST_CALL   = 2'd2;
  localparam logic [DEST_W-1:0] DST_RETURN = 2'd3;

  // Resolved control action after the condition has been applied
  typedef enum logic [2:0] {
    ACT_SEQ    = 3'd0,
    ACT_JUMP   = 3'd1,
    ACT_BRANCH = 3'd2,
    ACT_CALL   = 3'd3,
    ACT_RETURN = 3'd4
  } pcu_act_e;

endpackage

// File: rtl/pcu_rst_sync.sv
module pcu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pcu_decode.sv
module pcu_decode
  import pcu_pkg::*;
(
  input  logic              mv_valid,
  input  logic [DEST_W-1:0] mv_dest,
  input  logic              cond_flag,
  output pcu_act_e          act
);

  always_comb begin
    act = ACT_SEQ;
    if (mv_valid) begin
      unique case (mv_dest)
        DST_JUMP:   act = ACT_JUMP;
        DST_BRANCH: act = cond_flag ? ACT_BRANCH : ACT_SEQ;
        DST_CALL:   act = ACT_CALL;
        DST_RETURN: act = cond_flag ? ACT_RETURN : ACT_SEQ;
        default:    act = ACT_SEQ;
      endcase
    end
  end

endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [DATA_W-1:0] push_data,
  output logic [DATA_W-1:0] top_data,
  output logic              empty,
  output logic              full,
  output logic              ovf_sticky,
  output logic              unf_sticky
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ovf_q, ovf_d;
  logic              unf_q, unf_d;
  logic              push_ok, pop_ok;
  logic [IDX_W-1:0]  rd_idx;
  logic [DATA_W-1:0] mem [DEPTH];

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign push_ok = push_req && !full;
  assign pop_ok  = pop_req && !empty;
  assign rd_idx  = IDX_W'(cnt_q - CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (push_ok) begin
      cnt_d = cnt_q + CNT_W'(1);
    end else if (pop_ok) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
    ovf_d = ovf_q | (push_req && full);
    unf_d = unf_q | (pop_req && empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  // One enabled storage row per entry, no reset needed on data
  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    logic row_en;
    assign row_en = push_ok && (cnt_q == CNT_W'(i));
    always_ff @(posedge clk) begin
      if (row_en) begin
        mem[i] <= push_data;
      end
    end
  end

  assign top_data   = empty ? '0 : mem[rd_idx];
  assign ovf_sticky = ovf_q;
  assign unf_sticky = unf_q;

  // R7: an accepted push raises the occupancy by exactly one
  a_r7_push_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !full) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R7: occupancy never exceeds the configured depth
  a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R8: push on a full stack leaves occupancy and flags overflow
  a_r8_full_push: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full) |=> (ovf_sticky && $stable(cnt_q)));

  // R9: pop on an empty stack flags underflow
  a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty) |=> (unf_sticky && empty));

  // R10: error flags never drop without reset
  a_r10_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_sticky |=> ovf_sticky);
  a_r10_unf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    unf_sticky |=> unf_sticky);

endmodule

// File: rtl/move_pc_unit.sv
module move_pc_unit
  import pcu_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned STACK_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mv_valid,
  input  logic [1:0]        mv_dest,
  input  logic [ADDR_W-1:0] mv_data,
  input  logic              cond_flag,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              stk_overflow,
  output logic              stk_underflow
);

  logic              rst_i_n;
  pcu_act_e          act;
  logic [ADDR_W-1:0] pc_q, pc_d, pc_inc, ret_top;
  logic              stk_empty, stk_full;
  logic              push_req, pop_req;

  pcu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  pcu_decode u_decode (
    .mv_valid  (mv_valid),
    .mv_dest   (mv_dest),
    .cond_flag (cond_flag),
    .act       (act)
  );

  assign pc_inc   = pc_q + ADDR_W'(1);
  assign push_req = (act == ACT_CALL);
  assign pop_req  = (act == ACT_RETURN);

  pcu_ret_stack #(.DEPTH(STACK_DEPTH), .DATA_W(ADDR_W)) u_stack (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .push_req   (push_req),
    .pop_req    (pop_req),
    .push_data  (pc_inc),
    .top_data   (ret_top),
    .empty      (stk_empty),
    .full       (stk_full),
    .ovf_sticky (stk_overflow),
    .unf_sticky (stk_underflow)
  );

  always_comb begin
    pc_d = pc_inc;
    unique case (act)
      ACT_JUMP:   pc_d = mv_data;
      ACT_CALL:   pc_d = mv_data;
      ACT_BRANCH: pc_d = pc_q + mv_data;
      ACT_RETURN: pc_d = stk_empty ? pc_inc : ret_top;
      default:    pc_d = pc_inc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  assign fetch_addr = pc_q;

  // R2: without a move the counter steps by one
  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_i_n)
    !mv_valid |=> (fetch_addr == $past(fetch_addr) + ADDR_W'(1)));

  // R3: a jump lands on the moved value
  a_r3_jump_target: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mv_valid && mv_dest == DST_JUMP) |=> (fetch_addr == $past(mv_data)));

  // R4: a taken branch is relative to the current counter
  a_r4_branch_taken: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mv_valid && mv_dest == DST_BRANCH && cond_flag)
      |=> (fetch_addr == $past(fetch_addr) + $past(mv_data)));

  // R5: a call always lands on the moved value
  a_r5_call_target: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mv_valid && mv_dest == DST_CALL) |=> (fetch_addr == $past(mv_data)));

  // R6: a return with the flag clear just steps
  a_r6_ret_not_taken: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mv_valid && mv_dest == DST_RETURN && !cond_flag)
      |=> (fetch_addr == $past(fetch_addr) + ADDR_W'(1)));

endmodule

// File: tb/move_pc_unit_tb_top.sv
module move_pc_unit_tb_top;

  localparam int unsigned AW  = 16;
  localparam int unsigned DEP = 8;

  logic          clk;
  logic          rst_n;
  logic          mv_valid;
  logic [1:0]    mv_dest;
  logic [AW-1:0] mv_data;
  logic          cond_flag;
  logic [AW-1:0] fetch_addr;
  logic          stk_overflow;
  logic          stk_underflow;

  move_pc_unit #(.ADDR_W(AW), .STACK_DEPTH(DEP)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .mv_valid      (mv_valid),
    .mv_dest       (mv_dest),
    .mv_data       (mv_data),
    .cond_flag     (cond_flag),
    .fetch_addr    (fetch_addr),
    .stk_overflow  (stk_overflow),
    .stk_underflow (stk_underflow)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    logic [AW-1:0] pc;
    logic          ovf;
    logic          unf;
    string         tag;
  } exp_t;

  exp_t          sb_q[$];
  logic [AW-1:0] m_stack[$];
  logic [AW-1:0] m_pc;
  logic          m_ovf, m_unf;
  int            n_checks = 0;
  int            n_errors = 0;
  bit            finished = 0;

  task automatic check(input string tag, input logic [AW-1:0] act_pc, input logic [AW-1:0] exp_pc,
                       input logic act_o, input logic exp_o, input logic act_u, input logic exp_u);
    n_checks++;
    if (act_pc !== exp_pc || act_o !== exp_o || act_u !== exp_u) begin
      n_errors++;
      $display("FAIL %s: pc=%h ovf=%b unf=%b expected pc=%h ovf=%b unf=%b",
               tag, act_pc, act_o, act_u, exp_pc, exp_o, exp_u);
    end
  endtask

  // Monitor: compare each result one edge after its move was driven
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, fetch_addr, e.pc, stk_overflow, e.ovf, stk_underflow, e.unf);
    end
  end

  // Driver: apply one move on the falling edge and predict its result
  task automatic drive(input logic v, input logic [1:0] d, input logic [AW-1:0] data,
                       input logic c, input string tag);
    exp_t e;
    @(negedge clk);
    mv_valid  = v;
    mv_dest   = d;
    mv_data   = data;
    cond_flag = c;
    if (!v) begin
      m_pc = m_pc + 1'b1;
    end else begin
      case (d)
        2'd0: m_pc = data;
        2'd1: m_pc = c ? m_pc + data : m_pc + 1'b1;
        2'd2: begin
          if (m_stack.size() < DEP) m_stack.push_back(m_pc + 1'b1);
          else m_ovf = 1'b1;
          m_pc = data;
        end
        default: begin
          if (!c) m_pc = m_pc + 1'b1;
          else if (m_stack.size() == 0) begin
            m_unf = 1'b1;
            m_pc  = m_pc + 1'b1;
          end else m_pc = m_stack.pop_back();
        end
      endcase
    end
    e.pc = m_pc; e.ovf = m_ovf; e.unf = m_unf; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; mv_valid = 1'b0; mv_dest = '0; mv_data = '0; cond_flag = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 in reset", fetch_addr, '0, stk_overflow, 1'b0, stk_underflow, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 release edge 1", fetch_addr, '0, stk_overflow, 1'b0, stk_underflow, 1'b0);
    @(posedge clk); #1;
    check("R1 release edge 2", fetch_addr, '0, stk_overflow, 1'b0, stk_underflow, 1'b0);
    m_pc = '0; m_ovf = 1'b0; m_unf = 1'b0; m_stack.delete();
  endtask

  initial begin
    rst_n = 1'b0; mv_valid = 1'b0; mv_dest = '0; mv_data = '0; cond_flag = 1'b0;
    do_reset();
    // R1 counting starts, R2 idle steps with junk on unused inputs
    drive(0, 2'd0, 16'hBEEF, 1, "R1 first count");
    for (int i = 0; i < 4; i++) drive(0, 2'(i), 16'h0F0F + 16'(i), i[0], "R2 idle junk");
    // R3 jump with either flag value
    drive(1, 2'd0, 16'h1234, 0, "R3 jump flag0");
    drive(1, 2'd0, 16'h0100, 1, "R3 jump flag1");
    // R4 branches: forward, backward, not taken
    drive(1, 2'd1, 16'd5, 1, "R4 branch fwd");
    drive(1, 2'd1, 16'hFFFD, 1, "R4 branch back");
    drive(1, 2'd1, 16'h0040, 0, "R4 branch not taken");
    // R2 wrap at the top of the address space
    drive(1, 2'd0, 16'hFFFF, 0, "R3 jump to top");
    drive(0, 2'd0, 16'h0, 0, "R2 wrap");
    // R5 / R6 / R7 nested calls and returns
    drive(1, 2'd2, 16'h2000, 0, "R5 call a");
    drive(1, 2'd2, 16'h3000, 1, "R5 call b");
    drive(1, 2'd2, 16'h4000, 0, "R5 call c");
    drive(1, 2'd3, 16'h0, 0, "R6 return flag0");
    drive(1, 2'd3, 16'h0, 1, "R7 pop c");
    drive(1, 2'd3, 16'h0, 1, "R7 pop b");
    drive(1, 2'd3, 16'h0, 1, "R7 pop a");
    // R9 return on empty stack, R10 holds afterwards
    drive(1, 2'd3, 16'h0, 1, "R9 empty return");
    drive(0, 2'd0, 16'h0, 0, "R10 unf held");
    // R8 fill to depth then overflow
    for (int i = 0; i < DEP; i++) drive(1, 2'd2, 16'h5000 + 16'(i * 16), 0, "R7 fill");
    drive(1, 2'd2, 16'h7777, 1, "R8 call when full");
    drive(1, 2'd1, 16'd3, 1, "R10 ovf held");
    for (int i = 0; i < DEP; i++) drive(1, 2'd3, 16'h0, 1, "R8 R7 unwind");
    drive(1, 2'd3, 16'h0, 1, "R9 empty again");
    // R10 flags clear only on reset
    @(negedge clk);
    do_reset();
    drive(0, 2'd0, 16'h0, 0, "R10 cleared by reset");
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule